// File: doc/BRIEF.md
# Cassette FSK Bit Writer

This block turns a stream of bytes into a one-bit square-wave signal for recording on audio tape. Every bit occupies one complete cycle on the line: high for a half-period, then low for an equal half-period. A short half-period encodes a zero and a long half-period encodes a one, so the bit value is carried by the cycle length. A recording opens with a long run of zero bits that lets a reader lock on. Each byte is then framed as a one start bit, eight data bits sent least significant first, and a parity bit that makes the framed count of ones odd.

A controller sets `page_cnt` to the number of 256-byte pages (the page size is a parameter) and pulses `start`. Bytes are pulled through a valid/ready handshake one byte ahead of the line. After the parity bit of the final byte, that same parity bit is sent a second time and the block returns to idle.

The control state machine has seven states. IDLE goes to LEADER on a start with a nonzero page count. LEADER replays zero bits until its count runs out, then goes to FRAME_START if a byte is held or to STALL if none is. FRAME_START goes to DATA, and DATA goes to PARITY after the eighth data bit. PARITY goes to FRAME_START or STALL while bytes remain, and to TRAIL after the last byte. STALL goes to FRAME_START once a byte arrives. TRAIL goes to IDLE when the repeated parity bit ends.

Top module: `tape_fsk_writer`

## Requirements
- R1: After reset and whenever idle, `tape_out`, `busy` and `in_ready` are low.
- R2: Every bit drives `tape_out` high for one half-period and then low for one half-period. The half-period is HALF_ZERO clock cycles for a 0 bit and HALF_ONE clock cycles for a 1 bit.
- R3: A `start` pulse seen while idle with a nonzero `page_cnt` makes `busy` and `tape_out` high from the next cycle. The line then carries LEADER_BITS zero bits.
- R4: Each byte is sent as a 1 start bit, then data bits 0 through 7 in that order, then a parity bit.
- R5: The parity bit makes the number of ones across the start bit, the eight data bits and the parity bit odd.
- R6: Exactly `page_cnt` × PAGE_BYTES bytes are accepted and sent. After the last byte's parity bit, that parity bit is sent once more. `busy` falls in the cycle after the low half of this repeated bit ends.
- R7: `in_ready` is high only during the last leader bit, during a parity bit while bytes remain, or while stalled, and only when no byte is already held. It drops in the cycle after a handshake.
- R8: If no byte is held when one is needed, `tape_out` stays low until a byte arrives. That byte then follows intact, with no bit lost or added.
- R9: A `start` pulse while busy, or with `page_cnt` equal to 0, has no effect.
- R10: When bytes are supplied in time, bits follow each other with no gap, so each low half is exactly as long as its high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a recording (single-cycle pulse) |
| page_cnt | input | PAGE_W | Number of pages to send, sampled at start |
| in_data | input | 8 | Byte offered by the source |
| in_valid | input | 1 | Source has a byte on in_data |
| in_ready | output | 1 | Block will take in_data at this edge |
| tape_out | output | 1 | Square-wave tape signal |
| busy | output | 1 | Recording in progress |

## Verification
`busy` and the first high half of the leader appear one cycle after the start edge, so the bench checks them at the falling edge that follows. Bit values and half-period lengths only become known when the next rising edge of `tape_out` arrives, or when `busy` falls for the final bit. A monitor therefore measures each high run and low run at falling edges, and the full bit sequence is compared with a list computed from the bytes once `busy` has dropped. `in_ready` is a function of registered state, so the source evaluates the handshake at the falling edge before the rising edge that completes it.

// File: rtl/tape_fsk_pkg.sv
package tape_fsk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEADER,
        ST_FRAME_START,
        ST_DATA,
        ST_PARITY,
        ST_TRAIL,
        ST_STALL
    } wr_state_t;
endpackage

// File: rtl/fsk_cell.sv
module fsk_cell #(
    parameter int HALF_ZERO = 12500,
    parameter int HALF_ONE  = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic launch_bit,
    output logic line,
    output logic bit_last
);
    localparam int HMAX = (HALF_ONE > HALF_ZERO) ? HALF_ONE : HALF_ZERO;
    localparam int HW   = $clog2(HMAX + 1);

    logic          active;
    logic          phase;   // 0 = high half, 1 = low half
    logic [HW-1:0] cnt;
    logic [HW-1:0] len;
    logic          at_end;

    assign at_end   = active && (cnt == len - HW'(1));
    assign bit_last = at_end && phase;
    assign line     = active && !phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= 1'b0;
            cnt    <= '0;
            len    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            phase  <= 1'b0;
            cnt    <= '0;
            len    <= launch_bit ? HW'(HALF_ONE) : HW'(HALF_ZERO);
        end else if (active) begin
            if (at_end) begin
                cnt <= '0;
                if (!phase) phase  <= 1'b1;
                else        active <= 1'b0;
            end else begin
                cnt <= cnt + HW'(1);
            end
        end
    end

    // R2: a launched bit always opens with its high half
    assert_launch_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> line);
    // R2: the line only rises when a bit is launched
    assert_rise_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line) |-> $past(launch));
    // R2: the half-period counter stays inside its length
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < len));
endmodule

// File: rtl/tape_fsk_writer.sv
module tape_fsk_writer
    import tape_fsk_pkg::*;
#(
    parameter int HALF_ZERO   = 12500,
    parameter int HALF_ONE    = 40000,
    parameter int LEADER_BITS = 16384,
    parameter int PAGE_BYTES  = 256,
    parameter int PAGE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_cnt,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tape_out,
    output logic              busy
);
    localparam int PB_W   = $clog2(PAGE_BYTES);
    localparam int TOT_W  = PAGE_W + PB_W + 1;
    localparam int LEAD_W = $clog2(LEADER_BITS + 1);

    wr_state_t         state, nxt;
    logic [LEAD_W-1:0] lead_cnt;
    logic [TOT_W-1:0]  bytes_left;
    logic [7:0]        sh;
    logic [2:0]        idx;
    logic              par;
    logic [7:0]        hold;
    logic              have;

    logic launch, launch_bit, load, bit_last, line, take;

    fsk_cell #(.HALF_ZERO(HALF_ZERO), .HALF_ONE(HALF_ONE)) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_bit (launch_bit),
        .line       (line),
        .bit_last   (bit_last)
    );

    // next state and bit launch decisions
    always_comb begin
        nxt        = state;
        launch     = 1'b0;
        launch_bit = 1'b0;
        load       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start && (page_cnt != '0)) begin
                    nxt    = ST_LEADER;
                    launch = 1'b1;
                end
            end
            ST_LEADER: begin
                if (bit_last) begin
                    if (lead_cnt != '0) begin
                        launch = 1'b1;
                    end else if (have) begin
                        load = 1'b1; launch = 1'b1; launch_bit = 1'b1;
                        nxt  = ST_FRAME_START;
                    end else begin
                        nxt = ST_STALL;
                    end
                end
            end
            ST_FRAME_START: begin
                if (bit_last) begin
                    launch = 1'b1; launch_bit = sh[0];
                    nxt    = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_last) begin
                    launch = 1'b1;
                    if (idx == 3'd7) begin
                        launch_bit = par;
                        nxt        = ST_PARITY;
                    end else begin
                        launch_bit = sh[0];
                    end
                end
            end
            ST_PARITY: begin
                if (bit_last) begin
                    if (bytes_left == '0) begin
                        launch = 1'b1; launch_bit = par;
                        nxt    = ST_TRAIL;
                    end else if (have) begin
                        load = 1'b1; launch = 1'b1; launch_bit = 1'b1;
                        nxt  = ST_FRAME_START;
                    end else begin
                        nxt = ST_STALL;
                    end
                end
            end
            ST_TRAIL: begin
                if (bit_last) nxt = ST_IDLE;
            end
            ST_STALL: begin
                if (have) begin
                    load = 1'b1; launch = 1'b1; launch_bit = 1'b1;
                    nxt  = ST_FRAME_START;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lead_cnt   <= '0;
            bytes_left <= '0;
            sh         <= '0;
            idx        <= '0;
            par        <= 1'b0;
            hold       <= '0;
            have       <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && launch) begin
                lead_cnt   <= LEAD_W'(LEADER_BITS - 1);
                bytes_left <= TOT_W'(page_cnt) * TOT_W'(PAGE_BYTES);
            end
            if (state == ST_LEADER && bit_last && lead_cnt != '0)
                lead_cnt <= lead_cnt - LEAD_W'(1);
            if (load) begin
                sh         <= hold;
                par        <= ^hold;
                bytes_left <= bytes_left - TOT_W'(1);
                have       <= 1'b0;
            end else if (take) begin
                hold <= in_data;
                have <= 1'b1;
            end
            if (state == ST_FRAME_START && bit_last) begin
                sh  <= sh >> 1;
                idx <= '0;
            end
            if (state == ST_DATA && bit_last && idx != 3'd7) begin
                sh  <= sh >> 1;
                idx <= idx + 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready = !have && (bytes_left != '0) &&
                   ((state == ST_LEADER && lead_cnt == '0) ||
                    state == ST_PARITY || state == ST_STALL);
        take     = in_valid && in_ready;
        busy     = (state != ST_IDLE);
        tape_out = line;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tape_out && !in_ready));
    assert_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && page_cnt != '0) |=> (busy && tape_out));
    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    assert_zero_pages_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && page_cnt == '0) |=> !busy);
endmodule

// File: tb/tb_tape_fsk_writer.sv
module tb_tape_fsk_writer;
    localparam int HZ    = 3;
    localparam int HO    = 8;
    localparam int LEAD  = 6;
    localparam int PB    = 4;
    localparam int SLOWN = 20;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] page_cnt = '0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, tape_out, busy;

    always #10 clk = ~clk;

    tape_fsk_writer #(.HALF_ZERO(HZ), .HALF_ONE(HO), .LEADER_BITS(LEAD),
                      .PAGE_BYTES(PB), .PAGE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_cnt(page_cnt),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tape_out(tape_out), .busy(busy));

    int checks = 0, errors = 0, cyc = 0;

    // source side
    logic [7:0] src [0:63];
    int src_n = 0, src_idx = 0, wait_cnt = 0;
    bit slow = 0, fire = 0, sprev_busy = 0;
    always @(negedge clk) begin
        if (!sprev_busy && busy) begin src_idx = 0; wait_cnt = 0; fire = 0; end
        if (fire) begin src_idx++; wait_cnt = 0; end
        if (in_ready) wait_cnt++;
        in_valid = busy && (src_idx < src_n) && (!slow || wait_cnt >= SLOWN);
        in_data  = src[src_idx & 63];
        fire     = in_valid && in_ready;
        sprev_busy = busy;
    end

    // line monitor
    int rec_hi [0:255];
    int rec_lo [0:255];
    int nrec = 0, hi = 0, lo = 0;
    bit prev_line = 0, prev_busy = 0;
    always @(negedge clk) begin
        if (!prev_busy && busy) begin nrec = 0; hi = 0; lo = 0; end
        if (tape_out) begin
            if (!prev_line) begin
                if (hi != 0 && nrec < 256) begin rec_hi[nrec] = hi; rec_lo[nrec] = lo; nrec++; end
                hi = 0; lo = 0;
            end
            hi++;
        end else if (busy) begin
            lo++;
        end
        if (prev_busy && !busy) begin
            if (hi != 0 && nrec < 256) begin rec_hi[nrec] = hi; rec_lo[nrec] = lo; nrec++; end
            hi = 0; lo = 0;
        end
        prev_line = tape_out;
        prev_busy = busy;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT) begin
            errors++;
            $display("FAIL R6 watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic bit odd_parity(input logic [7:0] d);
        return ((1 + $countones(d)) % 2 == 0);
    endfunction

    task automatic run(input int pages, input bit slow_mode, input bit poke);
        bit exp [0:255];
        int ne = 0, gaps = 0;
        for (int i = 0; i < LEAD; i++) begin exp[ne] = 1'b0; ne++; end
        for (int b = 0; b < pages * PB; b++) begin
            exp[ne] = 1'b1; ne++;                                  // R4 start bit
            for (int k = 0; k < 8; k++) begin exp[ne] = src[b][k]; ne++; end
            exp[ne] = odd_parity(src[b]); ne++;                    // R5
        end
        exp[ne] = exp[ne-1]; ne++;                                 // R6 repeated parity
        src_n = pages * PB;
        slow  = slow_mode;
        page_cnt = 8'(pages);
        start = 1'b1;
        tick();
        start = 1'b0;
        check(busy == 1'b1 && tape_out == 1'b1, "R3 start", {busy, tape_out}, 3);
        check(in_ready == 1'b0, "R7 no ready in first leader bit", in_ready, 0);
        for (int w = 0; busy; w++) begin
            if (poke && w == 30) begin start = 1'b1; page_cnt = 8'd7; end
            else start = 1'b0;
            tick();
        end
        start = 1'b0;
        tick(); tick();
        check(nrec == ne, "R6 bit count", nrec, ne);
        check(src_idx == src_n, "R6 bytes accepted", src_idx, src_n);
        for (int i = 0; i < ne && i < nrec; i++) begin
            int v;
            v = (rec_hi[i] == HO) ? 1 : ((rec_hi[i] == HZ) ? 0 : 2);
            check(v == int'(exp[i]), (i < LEAD) ? "R3 leader bit" : "R4 R5 frame bit", v, exp[i]);
            if (slow_mode) begin
                check(rec_lo[i] >= rec_hi[i], "R8 low half", rec_lo[i], rec_hi[i]);
                if (rec_lo[i] > rec_hi[i]) gaps++;
            end else begin
                check(rec_lo[i] == rec_hi[i], "R2 R10 low half", rec_lo[i], rec_hi[i]);
            end
        end
        if (slow_mode) check(gaps > 0, "R8 stall seen", gaps, 1);
        check(tape_out == 1'b0 && in_ready == 1'b0, "R1 idle after run", {tape_out, in_ready}, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 64; i++) src[i] = 8'h00;
        repeat (3) tick();
        check(tape_out == 1'b0 && busy == 1'b0 && in_ready == 1'b0, "R1 reset", {tape_out, busy, in_ready}, 0);
        rst_n = 1'b1;
        tick();
        // R9: zero pages ignored
        page_cnt = 8'd0; start = 1'b1; tick(); start = 1'b0;
        repeat (4) tick();
        check(busy == 1'b0 && tape_out == 1'b0, "R9 zero pages", {busy, tape_out}, 0);
        // directed parity corners
        src[0] = 8'h00; src[1] = 8'hFF; src[2] = 8'h01; src[3] = 8'h80;
        run(1, 1'b0, 1'b0);
        // random pages and bytes
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
            run(int'($urandom_range(1, 3)), 1'b0, 1'b0);
        end
        // R8: late source
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        run(2, 1'b1, 1'b0);
        // R9: start while busy
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        run(1, 1'b0, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule